// File: doc/BRIEF.md
# Byte-Lane SRAM Pin Decoder

This block is a synthesizable, scaled-down model of an asynchronous static RAM's pin behaviour. It is meant to serve as the target device when a memory controller is tested. A fast simulation clock samples the select, write strobe, read strobe, lane select, width mode and address pins on every rising edge. From these samples the block decides whether the device is idle, reading, writing or holding its outputs off. The decision acts on a small internal array of 16-bit words, and each data bit is either driven or left released.

The data bus is split into a separate input, output and per-bit output-enable. A harness can join the three into a tri-state bus and see high impedance wherever the enable is low. Writes follow the rule of a strobe-overlap window. The array changes only on the sampled edge where the window closes, and it stores the data seen on the last sample while the window was still open. In narrow (byte) mode, the top data pin carries the lowest address bit instead of data. That bit picks which half of the internal word a byte access touches.

Top module: `sram_lane_model`

## Requirements
- R1: When `en_a_n` is high or `en_b` is low at a sampling edge, `doe` is all zeros after that edge and the array is not written.
- R2: In word mode (`wide`=1), a sample with both `lo_n` and `hi_n` high is idle: `doe` is zero and no write window opens.
- R3: A selected, non-writing sample with `rd_n` high gives `doe`=0 after the edge.
- R4: A word-mode read sample drives bits 7:0 when `lo_n` is low and bits 15:8 when `hi_n` is low, with the addressed word's data. Undriven bits of `dout` read 0, and outputs change on the edge that samples the pins.
- R5: In byte mode (`wide`=0), `din[15]` is address bit -1 and bit 15 is never driven. A read gives `doe`=16'h00FF and places the low half (`din[15]`=0) or the high half (`din[15]`=1) of the word on `dout[7:0]`, whatever the lane selects are.
- R6: A word-mode write window is open while selected, `wr_n` is low and a lane select is low. On the first sample where it is closed, the lanes enabled on the last open sample take that sample's `din`, and the other lane keeps its value.
- R7: A byte-mode write stores `din[7:0]` into the half of the word chosen by `din[15]`, with the same end-of-window timing.
- R8: Address bits at and above log2(`DEPTH`) are ignored; the word index is the low bits of `addr`.
- R9: `clash` is 1 after an edge whose sample has `wr_n` and `rd_n` both low while `doe` was nonzero just before that edge, and 0 otherwise.
- R10: Reset clears `dout`, `doe`, `clash`, any open write window and every array word to zero.
- R11: A read sampled on the same edge that closes a write window returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_a_n | input | 1 | Primary chip enable, active low |
| en_b | input | 1 | Secondary chip enable, active high |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Output enable, active low |
| lo_n | input | 1 | Lower lane select, active low |
| hi_n | input | 1 | Upper lane select, active low |
| wide | input | 1 | 1 = 16-bit word mode, 0 = byte mode |
| addr | input | PIN_AW | Word address; upper bits ignored |
| din | input | 16 | Data pins as seen by the device; bit 15 is address bit -1 in byte mode |
| dout | output | 16 | Data driven by the device |
| doe | output | 16 | Per-bit drive enable (0 = high impedance) |
| clash | output | 1 | Write strobe seen while outputs are still driven |

## Verification
The bench targets these corner cases:
- **Changing data during a write.** `din` changes while a write window is open. A design that stores at window start, or on every sample, keeps stale or partial data.
- **One-lane writes.** Writes touch only the upper lane or only one byte half. A design with a wrong lane mask overwrites the neighbouring byte.
- **Byte-mode reads.** These run with both lane selects high. A design that honours the selects there goes idle, and one that drives bit 15 collides with the address bit.
- **Read on the window-close edge.** A read is sampled on the edge that closes a write, and a write strobe arrives while a read is still driving. A design that returns stale data there, or that mistimes `clash`, is reported.

// File: rtl/sram_lane_pkg.sv
`timescale 1ns/1ps
package sram_lane_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_OFF   = 2'd1,
        OP_READ  = 2'd2,
        OP_WRITE = 2'd3
    } op_e;

    typedef struct packed {
        logic [15:0] dout;
        logic [15:0] doe;
        logic        clash;
    } pin_out_t;
endpackage

// File: rtl/lane_decode.sv
`timescale 1ns/1ps
module lane_decode
    import sram_lane_pkg::*;
#(
    parameter int PIN_AW = 22,
    parameter int IDX_W  = 4
) (
    input  logic              en_a_n,
    input  logic              en_b,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              lo_n,
    input  logic              hi_n,
    input  logic              wide,
    input  logic [PIN_AW-1:0] addr,
    input  logic [15:0]       din,
    output op_e               op,
    output logic [IDX_W-1:0]  idx,
    output logic [1:0]        lanes,
    output logic              half,
    output logic [15:0]       wdata
);
    logic sel;
    logic unused_upper_addr;

    assign unused_upper_addr = ^addr[PIN_AW-1:IDX_W];

    always_comb begin
        sel  = !en_a_n && en_b;
        half = din[15];
        idx  = addr[IDX_W-1:0];
        if (wide) begin
            lanes = {!hi_n, !lo_n};
            wdata = din;
        end else begin
            lanes = half ? 2'b10 : 2'b01;
            wdata = {din[7:0], din[7:0]};
        end
        if (!sel || (wide && lo_n && hi_n)) begin
            op = OP_IDLE;
        end else if (!wr_n) begin
            op = OP_WRITE;
        end else if (rd_n) begin
            op = OP_OFF;
        end else begin
            op = OP_READ;
        end
    end
endmodule

// File: rtl/write_window.sv
`timescale 1ns/1ps
module write_window #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       mask,
    input  logic [15:0]      data,
    output logic             commit,
    output logic [IDX_W-1:0] c_idx,
    output logic [1:0]       c_mask,
    output logic [15:0]      c_data
);
    typedef struct packed {
        logic             open;
        logic [IDX_W-1:0] idx;
        logic [1:0]       mask;
        logic [15:0]      data;
    } win_t;

    win_t win_d, win_q;

    always_comb begin
        win_d  = win_q;
        commit = win_q.open && !active;
        if (active) begin
            win_d.open = 1'b1;
            win_d.idx  = idx;
            win_d.mask = mask;
            win_d.data = data;
        end else begin
            win_d.open = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign c_idx  = win_q.idx;
    assign c_mask = win_q.mask;
    assign c_data = win_q.data;
endmodule

// File: rtl/lane_store.sv
`timescale 1ns/1ps
module lane_store #(
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic [IDX_W-1:0] c_idx,
    input  logic [1:0]       c_mask,
    input  logic [15:0]      c_data,
    input  logic [IDX_W-1:0] r_idx,
    output logic [15:0]      r_word
);
    logic [15:0] mem_d [DEPTH];
    logic [15:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (commit) begin
            for (int ln = 0; ln < 2; ln++) begin
                if (c_mask[ln]) mem_d[c_idx][ln*8 +: 8] = c_data[ln*8 +: 8];
            end
        end
        r_word = mem_d[r_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) mem_q[w] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end
endmodule

// File: rtl/sram_lane_model.sv
`timescale 1ns/1ps
module sram_lane_model
    import sram_lane_pkg::*;
#(
    parameter int PIN_AW = 22,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_a_n,
    input  logic              en_b,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              lo_n,
    input  logic              hi_n,
    input  logic              wide,
    input  logic [PIN_AW-1:0] addr,
    input  logic [15:0]       din,
    output logic [15:0]       dout,
    output logic [15:0]       doe,
    output logic              clash
);
    localparam int IDX_W = $clog2(DEPTH);

    op_e              op;
    logic [IDX_W-1:0] idx;
    logic [1:0]       lanes;
    logic             half;
    logic [15:0]      wdata;
    logic             commit;
    logic [IDX_W-1:0] c_idx;
    logic [1:0]       c_mask;
    logic [15:0]      c_data;
    logic [15:0]      r_word;
    pin_out_t         out_d, out_q;

    lane_decode #(.PIN_AW(PIN_AW), .IDX_W(IDX_W)) u_dec (
        .en_a_n(en_a_n), .en_b(en_b), .wr_n(wr_n), .rd_n(rd_n),
        .lo_n(lo_n), .hi_n(hi_n), .wide(wide), .addr(addr), .din(din),
        .op(op), .idx(idx), .lanes(lanes), .half(half), .wdata(wdata)
    );

    write_window #(.IDX_W(IDX_W)) u_win (
        .clk(clk), .rst_n(rst_n), .active(op == OP_WRITE),
        .idx(idx), .mask(lanes), .data(wdata),
        .commit(commit), .c_idx(c_idx), .c_mask(c_mask), .c_data(c_data)
    );

    lane_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .commit(commit), .c_idx(c_idx),
        .c_mask(c_mask), .c_data(c_data), .r_idx(idx), .r_word(r_word)
    );

    always_comb begin
        out_d       = '0;
        out_d.clash = !wr_n && !rd_n && (out_q.doe != 16'h0000);
        if (op == OP_READ) begin
            if (wide) begin
                out_d.doe  = {{8{lanes[1]}}, {8{lanes[0]}}};
                out_d.dout = r_word & out_d.doe;
            end else begin
                out_d.doe  = 16'h00FF;
                out_d.dout = {8'h00, half ? r_word[15:8] : r_word[7:0]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign dout  = out_q.dout;
    assign doe   = out_q.doe;
    assign clash = out_q.clash;
endmodule

// File: rtl/sram_lane_checks.sv
`timescale 1ns/1ps
module sram_lane_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        en_a_n,
    input logic        en_b,
    input logic        wr_n,
    input logic        rd_n,
    input logic        lo_n,
    input logic        hi_n,
    input logic        wide,
    input logic [15:0] doe,
    input logic        clash
);
    assert_standby_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_a_n || !en_b) |-> (doe == 16'h0000));

    assert_no_lane_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wide && lo_n && hi_n) |-> (doe == 16'h0000));

    assert_output_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!en_a_n && en_b && wr_n && rd_n) |-> (doe == 16'h0000));

    assert_low_lane_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wide && lo_n) |-> (doe[7:0] == 8'h00));

    assert_high_lane_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wide && hi_n) |-> (doe[15:8] == 8'h00));

    assert_byte_top_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!wide) |-> (doe[15:8] == 8'h00));

    assert_clash_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clash |-> $past(!wr_n && !rd_n));
endmodule

bind sram_lane_model sram_lane_checks u_checks (
    .clk(clk), .rst_n(rst_n), .en_a_n(en_a_n), .en_b(en_b), .wr_n(wr_n),
    .rd_n(rd_n), .lo_n(lo_n), .hi_n(hi_n), .wide(wide), .doe(doe), .clash(clash)
);

// File: tb/sram_lane_model_test.sv
`timescale 1ns/1ps
module sram_lane_model_test;
    localparam int PIN_AW = 22;
    localparam int DEPTH  = 16;

    logic clk = 1'b0;
    logic rst_n;
    logic en_a_n, en_b, wr_n, rd_n, lo_n, hi_n, wide;
    logic [PIN_AW-1:0] addr;
    logic [15:0] din;
    logic [15:0] dout, doe;
    logic clash;

    int n_checks = 0;
    int n_fails  = 0;

    logic [15:0] m_mem [DEPTH];
    logic        p_open;
    logic [3:0]  p_idx;
    logic [1:0]  p_mask;
    logic [15:0] p_data;
    logic [15:0] e_dout, e_doe;
    logic        e_clash;

    always #2.5 clk = ~clk;

    sram_lane_model #(.PIN_AW(PIN_AW), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .en_a_n(en_a_n), .en_b(en_b), .wr_n(wr_n),
        .rd_n(rd_n), .lo_n(lo_n), .hi_n(hi_n), .wide(wide), .addr(addr),
        .din(din), .dout(dout), .doe(doe), .clash(clash)
    );

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_fails++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        report();
    end

    function automatic string op_tag();
        if (en_a_n || !en_b) return "R1";
        if (wide && lo_n && hi_n) return "R2";
        if (!wr_n) return wide ? "R6" : "R7";
        if (rd_n) return "R3";
        return wide ? "R4" : "R5";
    endfunction

    task automatic model_reset();
        for (int w = 0; w < DEPTH; w++) m_mem[w] = 16'h0000;
        p_open = 1'b0; p_idx = '0; p_mask = '0; p_data = '0;
        e_dout = '0; e_doe = '0; e_clash = 1'b0;
    endtask

    task automatic model_edge();
        logic sel, open_now, nclash;
        logic [1:0] ln;
        logic [3:0] ix;
        logic [15:0] wd, word;
        sel = !en_a_n && en_b;
        ix  = addr[3:0];
        ln  = wide ? {!hi_n, !lo_n} : (din[15] ? 2'b10 : 2'b01);
        wd  = wide ? din : {din[7:0], din[7:0]};
        open_now = sel && !wr_n && (!wide || !(lo_n && hi_n));
        nclash = !wr_n && !rd_n && (e_doe != 16'h0000);
        if (p_open && !open_now) begin
            if (p_mask[0]) m_mem[p_idx][7:0]  = p_data[7:0];
            if (p_mask[1]) m_mem[p_idx][15:8] = p_data[15:8];
        end
        e_doe = '0; e_dout = '0;
        if (sel && wr_n && !rd_n && (!wide || !(lo_n && hi_n))) begin
            word = m_mem[ix];
            if (wide) begin
                e_doe  = {{8{!hi_n}}, {8{!lo_n}}};
                e_dout = word & e_doe;
            end else begin
                e_doe  = 16'h00FF;
                e_dout = {8'h00, din[15] ? word[15:8] : word[7:0]};
            end
        end
        if (open_now) begin
            p_idx = ix; p_mask = ln; p_data = wd;
        end
        p_open  = open_now;
        e_clash = nclash;
    endtask

    task automatic compare(input string tag);
        n_checks++;
        if (clash !== e_clash) begin
            n_fails++;
            $display("FAIL R9 (%s): clash actual=%b expected=%b", tag, clash, e_clash);
        end else if (doe !== e_doe || dout !== e_dout) begin
            n_fails++;
            $display("FAIL %s: doe/dout actual=%h/%h expected=%h/%h", tag, doe, dout, e_doe, e_dout);
        end
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        model_edge();
        #1;
        compare(tag);
    endtask

    task automatic expect_out(input string tag, input logic [15:0] exp_dout, input logic [15:0] exp_doe);
        n_checks++;
        if (dout !== exp_dout || doe !== exp_doe) begin
            n_fails++;
            $display("FAIL %s: dout/doe actual=%h/%h expected=%h/%h", tag, dout, doe, exp_dout, exp_doe);
        end
    endtask

    task automatic pins(input logic a_n, input logic b, input logic w_n, input logic r_n,
                        input logic l_n, input logic h_n, input logic wd,
                        input logic [PIN_AW-1:0] ad, input logic [15:0] d);
        en_a_n = a_n; en_b = b; wr_n = w_n; rd_n = r_n;
        lo_n = l_n; hi_n = h_n; wide = wd; addr = ad; din = d;
    endtask

    initial begin
        void'($urandom(32'h0000_5EED));
        model_reset();
        pins(1, 0, 1, 1, 1, 1, 1, '0, '0);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        expect_out("R10 reset outputs", 16'h0000, 16'h0000);
        compare("R10");
        rst_n = 1'b1;

        // R10: array starts cleared
        pins(0, 1, 1, 0, 0, 0, 1, 22'd3, 16'h0);
        tick("R10");
        expect_out("R10 cleared word", 16'h0000, 16'hFFFF);

        // R6: data changes mid-window, last open sample is stored
        pins(0, 1, 0, 1, 0, 0, 1, 22'd5, 16'hA55A); tick("R6");
        din = 16'h9999; tick("R6");
        din = 16'h1234; tick("R6");
        pins(0, 1, 1, 1, 0, 0, 1, 22'd5, 16'hFFFF); tick("R6");
        pins(0, 1, 1, 0, 0, 0, 1, 22'd5, 16'h0); tick("R6");
        expect_out("R6 word write", 16'h1234, 16'hFFFF);

        // R6: upper lane only, low lane kept
        pins(0, 1, 0, 1, 1, 0, 1, 22'd5, 16'hFFFF); tick("R6");
        pins(0, 1, 1, 1, 1, 1, 1, 22'd5, 16'h0); tick("R2");
        pins(0, 1, 1, 0, 0, 0, 1, 22'd5, 16'h0); tick("R6");
        expect_out("R6 upper lane write", 16'hFF34, 16'hFFFF);

        // R4: single-lane reads
        pins(0, 1, 1, 0, 0, 1, 1, 22'd5, 16'h0); tick("R4");
        expect_out("R4 low lane read", 16'h0034, 16'h00FF);
        pins(0, 1, 1, 0, 1, 0, 1, 22'd5, 16'h0); tick("R4");
        expect_out("R4 high lane read", 16'hFF00, 16'hFF00);

        // R8: upper address bits ignored
        pins(0, 1, 0, 1, 0, 0, 1, 22'h3F_FFF7, 16'hBEEF); tick("R8");
        pins(0, 1, 1, 1, 0, 0, 1, 22'd0, 16'h0); tick("R8");
        pins(0, 1, 1, 0, 0, 0, 1, 22'd7, 16'h0); tick("R8");
        expect_out("R8 truncated address", 16'hBEEF, 16'hFFFF);

        // R7: byte write to high half of word 2
        pins(0, 1, 0, 1, 1, 1, 0, 22'd2, 16'h80AB); tick("R7");
        pins(0, 1, 1, 1, 1, 1, 0, 22'd2, 16'h0); tick("R7");
        pins(0, 1, 1, 0, 0, 0, 1, 22'd2, 16'h0); tick("R7");
        expect_out("R7 byte write high half", 16'hAB00, 16'hFFFF);

        // R5: byte reads with both selects high
        pins(0, 1, 1, 0, 1, 1, 0, 22'd2, 16'h0000); tick("R5");
        expect_out("R5 byte read low half", 16'h0000, 16'h00FF);
        pins(0, 1, 1, 0, 1, 1, 0, 22'd2, 16'h8000); tick("R5");
        expect_out("R5 byte read high half", 16'h00AB, 16'h00FF);

        // R1: deselected writes leave data alone
        pins(1, 1, 0, 1, 0, 0, 1, 22'd5, 16'h0000); tick("R1");
        pins(0, 0, 0, 1, 0, 0, 1, 22'd5, 16'h0000); tick("R1");
        pins(0, 0, 1, 0, 0, 0, 1, 22'd5, 16'h0000); tick("R1");
        expect_out("R1 deselected read", 16'h0000, 16'h0000);
        // R2: no lane selected in word mode
        pins(0, 1, 0, 1, 1, 1, 1, 22'd5, 16'h0000); tick("R2");
        pins(0, 1, 1, 0, 1, 1, 1, 22'd5, 16'h0000); tick("R2");
        pins(0, 1, 1, 0, 0, 0, 1, 22'd5, 16'h0000); tick("R1");
        expect_out("R1 R2 data untouched", 16'hFF34, 16'hFFFF);

        // R3: output off
        pins(0, 1, 1, 1, 0, 0, 1, 22'd5, 16'h0000); tick("R3");
        expect_out("R3 output disable", 16'h0000, 16'h0000);

        // R9 / R11: write while driven, then read on closing edge
        pins(0, 1, 1, 0, 0, 0, 1, 22'd9, 16'h0); tick("R9");
        pins(0, 1, 0, 0, 0, 0, 1, 22'd9, 16'h0F0F); tick("R9");
        n_checks++;
        if (clash !== 1'b1) begin
            n_fails++;
            $display("FAIL R9: clash actual=%b expected=1", clash);
        end
        tick("R9");
        n_checks++;
        if (clash !== 1'b0) begin
            n_fails++;
            $display("FAIL R9: clash actual=%b expected=0", clash);
        end
        wr_n = 1'b1; tick("R11");
        expect_out("R11 read on closing edge", 16'h0F0F, 16'hFFFF);

        // Random traffic against the bench model
        for (int i = 0; i < 4000; i++) begin
            en_a_n = ($urandom % 8) == 0;
            en_b   = ($urandom % 8) != 0;
            wr_n   = ($urandom % 3) != 0;
            rd_n   = ($urandom % 2) != 0;
            lo_n   = ($urandom % 4) == 0;
            hi_n   = ($urandom % 4) == 0;
            wide   = ($urandom % 5) != 0;
            addr   = PIN_AW'($urandom);
            din    = 16'($urandom);
            tick(op_tag());
        end

        report();
    end
endmodule